// File: doc/BRIEF.md
# Palette Memory Byte Port

This block places a 256-word by 16-bit color table behind a narrow 8-bit register port. The processor first loads a word address and then moves bytes through one shared data port. Each data access uses the byte named by an internal select bit: the low byte first, then the high byte. The select bit toggles on every accepted data access. After each high-byte access the word address steps forward by one.

Writes and reads work differently. A low-byte write only fills a holding register. The table itself is written only when the high byte arrives, and then it receives the whole word at once. Reads get one byte straight from the table on every access, with no word held between the two halves.

While the display is active the renderer owns the table. Processor writes and reads are then refused, but the sequencing still moves on. Every table update also appears on a word-wide write port, so a mirror copy or a renderer-side cache can follow it. There is no back-pressure: every strobe is taken in the cycle it is asserted. Read data comes with a one-cycle valid pulse and has no ready input.

Top module: `pal_byte_port`

## Requirements
- R1: After reset the word address is 0, the byte select is low, `rd_valid` and `tbl_we` are 0, and every table word reads back as 0.
- R2: An `addr_wr` strobe loads `addr_in` into the word address and forces the byte select to low.
- R3: A data write with the select low stores the byte in the holding register only; `tbl_we` stays 0 in that cycle.
- R4: A data write with the select high raises `tbl_we` for that cycle. `tbl_waddr` is the current word address. `tbl_wdata` carries the holding register in bits 7:0 and the written byte in bits 15:8.
- R5: Bit 7 of a high byte that is written is dropped: bit 15 of every committed word is 0.
- R6: A data read returns the low byte (bits 7:0) of the addressed word when the select is low, and the high byte (bits 15:8) when it is high. `rd_data` is valid with `rd_valid` = 1 in the cycle after the strobe; `rd_valid` is 0 at all other times.
- R7: The byte select toggles on every accepted data access, whether it is a read or a write, so reads and writes can be interleaved.
- R8: The word address increases by one after every accepted high-byte access and wraps from 255 to 0.
- R9: While `display_active` is 1, a data write changes neither the table nor the holding register, and a data read returns 0x00. The byte select and the word address still advance as in R7 and R8.
- R10: When strobes coincide, `addr_wr` wins and any data strobe in that cycle is dropped. Between the two data strobes, `data_wr` wins over `data_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Word-address load strobe |
| addr_in | input | 8 | Word address to load |
| data_wr | input | 1 | Data-port write strobe |
| data_rd | input | 1 | Data-port read strobe |
| wr_byte | input | 8 | Byte for a data-port write |
| display_active | input | 1 | Renderer owns the table; processor access is refused |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| tbl_we | output | 1 | Word commit strobe |
| tbl_waddr | output | 8 | Address of the committed word |
| tbl_wdata | output | 16 | Committed word |

## Verification
The bench goes after the point where the select sits high and an address load arrives. A design that forgot to clear the select there would pair the next byte with the wrong half, and every later word would be skewed. Runs of writes through address 255 catch a counter that saturates or skips the wrap; the readback at 0 then shows stale data. Blocked writes placed between the low and high byte of a word expose a latch that the renderer window can corrupt. They also expose a sequencer that freezes during blocking, which shifts every following address. Interleaved reads and writes check that one select bit serves both directions, and the commit port checks that bit 15 is always cleared.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic {SEL_LO = 1'b0, SEL_HI = 1'b1} bsel_e;
endpackage

// File: rtl/pal_seq.sv
module pal_seq
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              acc,
  output bsel_e             sel,
  output logic [ADDR_W-1:0] waddr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel   <= SEL_LO;
      waddr <= '0;
    end else if (addr_wr) begin
      sel   <= SEL_LO;
      waddr <= addr_in;
    end else if (acc) begin
      sel <= (sel == SEL_LO) ? SEL_HI : SEL_LO;
      if (sel == SEL_HI) waddr <= waddr + 1'b1;
    end
  end

  // R2
  a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (sel == SEL_LO) && (waddr == $past(addr_in)));
  // R7
  a_r7_sel_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !addr_wr) |=> (sel != $past(sel)));
  // R8
  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !addr_wr && sel == SEL_HI) |=> (waddr == $past(waddr) + 1'b1));
  // R8: the address holds after a low-byte access
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !addr_wr && sel == SEL_LO) |=> $stable(waddr));
endmodule

// File: rtl/pal_wlatch.sv
module pal_wlatch
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned HI_KEEP = 7,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  bsel_e             sel,
  input  logic              blocked,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [ADDR_W-1:0] waddr,
  output logic              we,
  output logic [ADDR_W-1:0] wa,
  output logic [WORD_W-1:0] wd
);
  logic [BYTE_W-1:0] hold_q;
  logic [BYTE_W-1:0] hi_byte;

  generate
    if (HI_KEEP < BYTE_W) begin : g_mask
      assign hi_byte = {{(BYTE_W-HI_KEEP){1'b0}}, wbyte[HI_KEEP-1:0]};
    end else begin : g_full
      assign hi_byte = wbyte;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= '0;
    else if (wr_acc && sel == SEL_LO && !blocked) hold_q <= wbyte;
  end

  always_comb begin
    we = wr_acc && (sel == SEL_HI) && !blocked;
    wa = waddr;
    wd = {hi_byte, hold_q};
  end

  // R3
  a_r3_low_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel == SEL_LO) |-> !we);
  // R9
  a_r9_blocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && blocked) |=> $stable(hold_q));
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [WORD_W-1:0] wd,
  input  logic              rd_acc,
  input  bsel_e             rsel,
  input  logic              blocked,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [WORD_W-1:0] tbl [DEPTH];
  logic [WORD_W-1:0] word_now;

  assign word_now = tbl[wa];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) begin
        if (blocked)             rd_data <= '0;
        else if (rsel == SEL_HI) rd_data <= word_now[WORD_W-1:BYTE_W];
        else                     rd_data <= word_now[BYTE_W-1:0];
      end
    end
  end

  // R6
  a_r6_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> rd_valid);
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !rd_valid);
endmodule

// File: rtl/pal_byte_port.sv
module pal_byte_port
  import pal_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned HI_KEEP = 7,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              display_active,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              tbl_we,
  output logic [ADDR_W-1:0] tbl_waddr,
  output logic [WORD_W-1:0] tbl_wdata
);
  logic              wr_acc, rd_acc;
  bsel_e             sel;
  logic [ADDR_W-1:0] waddr;

  // R10: address load first, then write, then read
  assign wr_acc = data_wr && !addr_wr;
  assign rd_acc = data_rd && !addr_wr && !data_wr;

  pal_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
    .acc(wr_acc || rd_acc), .sel(sel), .waddr(waddr)
  );

  pal_wlatch #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .HI_KEEP(HI_KEEP)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .sel(sel),
    .blocked(display_active), .wbyte(wr_byte), .waddr(waddr),
    .we(tbl_we), .wa(tbl_waddr), .wd(tbl_wdata)
  );

  pal_store #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wa(tbl_waddr), .wd(tbl_wdata),
    .rd_acc(rd_acc), .rsel(sel), .blocked(display_active),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // R9
  a_r9_no_commit_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    display_active |-> !tbl_we);
  // R5
  a_r5_top_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> !tbl_wdata[WORD_W-1]);
  // R10
  a_r10_addr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |-> !tbl_we);
endmodule

// File: tb/test_pal_byte_port.sv
module test_pal_byte_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0, display_active = 1'b0;
  logic [7:0] addr_in = '0, wr_byte = '0;
  logic [7:0] rd_data;
  logic       rd_valid, tbl_we;
  logic [7:0] tbl_waddr;
  logic [15:0] tbl_wdata;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_tbl [256];
  bit          m_sel;
  logic [7:0]  m_addr, m_hold;
  bit          pend;
  logic [7:0]  pend_exp;

  always #4 clk = ~clk;

  pal_byte_port i_pal_byte_port (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_in(addr_in),
    .data_wr(data_wr), .data_rd(data_rd), .wr_byte(wr_byte),
    .display_active(display_active), .rd_data(rd_data), .rd_valid(rd_valid),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input bit blk);
    if (blk) return 8'h00;
    return m_sel ? m_tbl[m_addr][15:8] : m_tbl[m_addr][7:0];
  endfunction

  // one bus cycle; read results are checked in the following cycle (R6)
  task automatic op(input bit aw, input bit dw, input bit dr, input bit blk, input logic [7:0] d);
    bit wacc, racc, commit;
    @(negedge clk);
    if (pend) begin
      chk("R6 rd_valid", rd_valid, 1);
      chk("R6 R9 rd_data", rd_data, pend_exp);
    end else chk("R6 idle rd_valid", rd_valid, 0);
    addr_wr = aw; data_wr = dw; data_rd = dr; display_active = blk;
    addr_in = d; wr_byte = d;
    wacc = dw && !aw;
    racc = dr && !aw && !dw;
    commit = wacc && m_sel && !blk;
    #1;
    chk("R3 R4 R9 R10 tbl_we", tbl_we, commit);
    if (commit) begin
      chk("R4 tbl_waddr", tbl_waddr, m_addr);
      chk("R4 R5 tbl_wdata", tbl_wdata, {1'b0, d[6:0], m_hold});
    end
    pend = racc;
    if (racc) pend_exp = exp_read(blk);
    if (aw) begin
      m_addr = d; m_sel = 0;
    end else if (wacc || racc) begin
      if (wacc && !blk) begin
        if (!m_sel) m_hold = d;
        else m_tbl[m_addr] = {1'b0, d[6:0], m_hold};
      end
      if (m_sel) m_addr = m_addr + 8'd1;
      m_sel = !m_sel;
    end
  endtask

  task automatic idle();
    op(0, 0, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < 256; i++) m_tbl[i] = '0;
    m_sel = 0; m_addr = 0; m_hold = 0; pend = 0; pend_exp = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 tbl_we", tbl_we, 0);
    rst_n = 1'b1;
    // R1: reset contents are zero, read from address 0
    op(0, 0, 1, 0, 0); op(0, 0, 1, 0, 0); idle();
    // R3 R4 R5: write word to 0x10 with bit 7 of the high byte set
    op(1, 0, 0, 0, 8'h10); op(0, 1, 0, 0, 8'h3c); op(0, 1, 0, 0, 8'hff);
    op(1, 0, 0, 0, 8'h10); op(0, 0, 1, 0, 0); op(0, 0, 1, 0, 0); idle();
    // R2: address load with select high clears select
    op(1, 0, 0, 0, 8'h20); op(0, 1, 0, 0, 8'h11); op(1, 0, 0, 0, 8'h21);
    op(0, 1, 0, 0, 8'h22); op(0, 1, 0, 0, 8'h33);
    // R8: wrap from 255 to 0
    op(1, 0, 0, 0, 8'hff); op(0, 1, 0, 0, 8'haa); op(0, 1, 0, 0, 8'h55);
    op(0, 1, 0, 0, 8'h77); op(0, 1, 0, 0, 8'h66);
    op(1, 0, 0, 0, 8'hff); for (int k = 0; k < 4; k++) op(0, 0, 1, 0, 0);
    // R9: blocked write between low and high, blocked read
    op(1, 0, 0, 0, 8'h40); op(0, 1, 0, 0, 8'h12); op(0, 1, 0, 1, 8'h99);
    op(0, 1, 0, 1, 8'h98); op(0, 1, 0, 0, 8'h34);
    op(1, 0, 0, 0, 8'h40); op(0, 0, 1, 1, 0); op(0, 0, 1, 0, 0);
    op(0, 0, 1, 0, 0); op(0, 0, 1, 0, 0);
    // R7: interleaved read then write on one word
    op(1, 0, 0, 0, 8'h50); op(0, 0, 1, 0, 0); op(0, 1, 0, 0, 8'h0f);
    op(1, 0, 0, 0, 8'h50); op(0, 0, 1, 0, 0); op(0, 0, 1, 0, 0);
    // R10: coinciding strobes
    op(1, 0, 0, 0, 8'h60); op(0, 1, 0, 0, 8'h01); op(1, 1, 1, 0, 8'h61);
    op(0, 1, 1, 0, 8'h02); op(0, 1, 1, 0, 8'h03);
    op(1, 0, 0, 0, 8'h61); op(0, 0, 1, 0, 0); op(0, 0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = $urandom % 16;
      bit blk = ($urandom % 8) == 0;
      logic [7:0] d = 8'($urandom);
      if (r == 0)      op(1, 0, 0, blk, d);
      else if (r < 8)  op(0, 1, 0, blk, d);
      else if (r < 14) op(0, 0, 1, blk, d);
      else if (r == 14) op(($urandom % 2) == 1, 1, 1, blk, d);
      else idle();
    end
    idle(); idle();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule